// File: doc/BRIEF.md
# Reset Cause and Control Register

This block keeps one 32-bit status word that tells software why the system last came out of reset, and lets software ask for a new system reset. Five bits carry meaning: a power-on flag, two software-requested causes (a full power-on style reset and an externally-initiated style reset), and two push-button causes (same two styles). The rest of the word always reads as zero. Hardware-reported causes are cleared by software writing ones to them. The software-request bits work the other way: writing a one sets them and raises a system reset request.

The block counts the system resets it has seen. The power-on flag is loaded only when the counter is zero. A software power-on request zeroes the counter, so the reset that follows reports power-on again. The block's own `rst` input starts it from a clean state. The `sysrst_evt` input marks each system reset and does not clear the block. The block does not distribute any reset; it only emits the one-cycle `reset_req` pulse.

Top module: `reset_cause_reg`

## Requirements
- R1: While `rst` is high and in the cycle after it, `cause_q`, `rd_data` and `reset_req` are all zero and the reset counter is zero.
- R2: Only bits 31 (power-on), 30 (software power-on), 29 (software external), 28 (button power-on) and 27 (button external) can ever be one. Bits 26:0 of `cause_q` and `rd_data` are always zero, whatever is written.
- R3: A write to the upper word clears each of bits 31, 28 and 27 that is written as one. Those bits are never set by a write.
- R4: A write to the upper word sets each of bits 30 and 29 that is written as one. Writing zero to them leaves them unchanged.
- R5: An upper-word write with bit 30 set clears the reset counter and makes `reset_req` high in the next cycle.
- R6: An upper-word write with bit 29 set also makes `reset_req` high in the next cycle. `reset_req` is high for one cycle per such write and is low after any cycle without such a write.
- R7: A `sysrst_evt` pulse while the counter is zero loads `cause_q` with only bit 31 set (0x80000000) and increments the counter.
- R8: A `sysrst_evt` pulse while the counter is nonzero leaves `cause_q` unchanged and increments the counter.
- R9: The counter saturates at its all-ones value (2**CNT_W-1) and never wraps back to zero on events alone.
- R10: The upper word is the one with address bit 2 set. Writes with address bit 2 clear change nothing and raise no request. Reads of that word return zero.
- R11: `rd_data` is registered. One cycle after `rd_en`, it holds the value `cause_q` had before any write in that same cycle. Without `rd_en` it reads zero.
- R12: When a write and `sysrst_evt` fall in the same cycle, the write takes effect first and the event second. A software power-on write together with an event therefore leaves exactly 0x80000000 and a counter of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high initialisation of the block itself |
| sysrst_evt | input | 1 | One-cycle marker of each system reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address within the 8-byte slot |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address within the 8-byte slot |
| rd_data | output | 32 | Registered read data |
| cause_q | output | 32 | Current register value |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
A register write and a system reset event can land in the same clock cycle. Their order matters: a software power-on write zeroes the counter, and the event then reloads the power-on flag, wiping the bit just set. The bench drives `sysrst_evt` together with upper-word writes of bit 30, then bit 29, then a clearing write. Each time it compares the register and the request against a model that applies the write first and the event second. It also runs more events than the small counter can hold, to tell saturation apart from wrap-around.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BIT_POR  = 31;
  localparam int unsigned BIT_SPOR = 30;
  localparam int unsigned BIT_SXIR = 29;
  localparam int unsigned BIT_BPOR = 28;
  localparam int unsigned BIT_BXIR = 27;

  localparam logic [WORD_W-1:0] POR_ONLY  = WORD_W'(1) << BIT_POR;
  localparam logic [WORD_W-1:0] W1C_MASK  = POR_ONLY | (WORD_W'(1) << BIT_BPOR)
                                          | (WORD_W'(1) << BIT_BXIR);
  localparam logic [WORD_W-1:0] SET_MASK  = (WORD_W'(1) << BIT_SPOR)
                                          | (WORD_W'(1) << BIT_SXIR);
  localparam logic [WORD_W-1:0] KEEP_MASK = W1C_MASK | SET_MASK;

  typedef struct packed {
    logic              hit;
    logic [WORD_W-1:0] clr_bits;
    logic [WORD_W-1:0] set_bits;
    logic              soft_por;
    logic              req;
  } wr_op_t;
endpackage

// File: rtl/rcc_wr_decode.sv
module rcc_wr_decode
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_BIT = 2
) (
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_data,
  output wr_op_t                 op
);
  logic [WORD_W-1:0] val;

  always_comb begin
    val         = wr_data & KEEP_MASK;
    op.hit      = wr_en & wr_addr[SEL_BIT];
    op.clr_bits = op.hit ? (val & W1C_MASK) : '0;
    op.set_bits = op.hit ? (val & SET_MASK) : '0;
    op.soft_por = op.hit & val[BIT_SPOR];
    op.req      = op.hit & (val[BIT_SPOR] | val[BIT_SXIR]);
  end
endmodule

// File: rtl/rcc_sat_counter.sv
module rcc_sat_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic             first,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // counter seen by an event in this cycle, after any same-cycle clear
  assign first = clr | (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (inc) begin
      if (first)                 cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end else if (clr) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/rcc_read_port.sv
module rcc_read_port
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] cause,
  output logic [WORD_W-1:0] rd_data_q
);
  always_ff @(posedge clk) begin
    if (rst)                           rd_data_q <= '0;
    else if (rd_en && rd_addr[SEL_BIT]) rd_data_q <= cause;
    else                               rd_data_q <= '0;
  end
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_BIT = 2,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sysrst_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [31:0]       cause_q,
  output logic              reset_req
);
  wr_op_t            op;
  logic              first;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] cause_nxt;

  rcc_wr_decode #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .op(op)
  );

  rcc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(op.soft_por), .inc(sysrst_evt),
    .first(first), .cnt_q(cnt_q)
  );

  rcc_read_port #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .cause(cause_q), .rd_data_q(rd_data)
  );

  // write applied first, reset event second
  always_comb begin
    cause_nxt = (cause_q & ~op.clr_bits) | op.set_bits;
    if (sysrst_evt && first) cause_nxt = POR_ONLY;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q   <= '0;
      reset_req <= 1'b0;
    end else begin
      cause_q   <= cause_nxt & KEEP_MASK;
      reset_req <= op.req;
    end
  end
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk #(
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned SEL_BIT = 2,
  parameter int unsigned CNT_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sysrst_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [31:0]       cause_q,
  input logic              reset_req,
  input logic [CNT_W-1:0]  cnt_q
);
  logic hi_wr;
  assign hi_wr = wr_en & wr_addr[SEL_BIT];

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cause_q[26:0] == 27'd0);
  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr && wr_data[31] && !sysrst_evt |=> !cause_q[31]);
  // R4
  set_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr && wr_data[29] && !sysrst_evt |=> cause_q[29]);
  // R5
  req_src_chk: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> $past(hi_wr && (wr_data[30] || wr_data[29])));
  // R6
  no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> !reset_req);
  // R9
  sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&cnt_q) && !(hi_wr && wr_data[30]) |=> (&cnt_q));
  // R10
  lo_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && !wr_addr[SEL_BIT] && !sysrst_evt |=> $stable(cause_q));
  // R10
  lo_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !rd_addr[SEL_BIT] |=> rd_data == 32'd0);
  // R12
  both_chk: assert property (@(posedge clk) disable iff (rst)
    hi_wr && wr_data[30] && sysrst_evt |=> cause_q == 32'h8000_0000);
endmodule

bind reset_cause_reg rcc_chk #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sysrst_evt(sysrst_evt), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .cause_q(cause_q), .reset_req(reset_req), .cnt_q(cnt_q)
);

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/1ps
module test_reset_cause_reg;
  localparam int CW   = 2;
  localparam int MAXC = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sysrst_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data, cause_q;
  logic        reset_req;

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string cur = "R1";

  logic [31:0] m_cause = '0, m_rd = '0;
  logic        m_req = 1'b0;
  int          m_cnt = 0;

  always #10 clk = ~clk;

  reset_cause_reg #(.ADDR_W(3), .SEL_BIT(2), .CNT_W(CW)) i_reset_cause_reg (
    .clk(clk), .rst(rst), .sysrst_evt(sysrst_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cause_q(cause_q), .reset_req(reset_req)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic model();
    logic [31:0] v;
    if (rst) begin
      m_cause = '0; m_cnt = 0; m_req = 0; m_rd = '0;
    end else begin
      m_rd  = (rd_en && rd_addr[2]) ? m_cause : 32'd0;
      v     = wr_data & 32'hF800_0000;
      m_req = wr_en && wr_addr[2] && (v[30] || v[29]);
      if (wr_en && wr_addr[2]) begin
        m_cause = (m_cause & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
        if (v[30]) m_cnt = 0;
      end
      if (sysrst_evt) begin
        if (m_cnt == 0) m_cause = 32'h8000_0000;
        if (m_cnt < MAXC) m_cnt++;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model();
    @(negedge clk);
    chk(cur, "cause model", cause_q, m_cause);
    chk(cur, "req model", {31'd0, reset_req}, {31'd0, m_req});
    chk(cur, "rd model", rd_data, m_rd);
  endtask

  task automatic idle();
    sysrst_evt = 0; wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit evt);
    wr_en = 1; wr_addr = a; wr_data = d; sysrst_evt = evt;
    step();
    idle();
  endtask

  task automatic rd(input logic [2:0] a);
    rd_en = 1; rd_addr = a;
    step();
    idle();
  endtask

  task automatic evt();
    sysrst_evt = 1;
    step();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur = "R1";
    step(); step();
    rst = 0;
    step();
    chk("R1", "cause after rst", cause_q, 32'd0);
    chk("R1", "req after rst", {31'd0, reset_req}, 32'd0);
    chk("R1", "rd after rst", rd_data, 32'd0);

    // R7 first event loads power-on only
    cur = "R7";
    evt();
    chk("R7", "cause first evt", cause_q, 32'h8000_0000);
    // R11 registered read
    cur = "R11";
    rd(3'd4);
    chk("R11", "rd hi", rd_data, 32'h8000_0000);
    // R10 low word reads zero
    cur = "R10";
    rd(3'd0);
    chk("R10", "rd lo", rd_data, 32'd0);

    // R8 later event keeps value
    cur = "R8";
    wr(3'd4, 32'h8000_0000, 0);
    chk("R3", "clear por", cause_q, 32'd0);
    evt();
    chk("R8", "evt cnt nonzero", cause_q, 32'd0);

    // R5 soft power-on write
    cur = "R5";
    wr(3'd4, 32'h4000_0000, 0);
    chk("R5", "req pulse", {31'd0, reset_req}, 32'd1);
    chk("R4", "set bit30", cause_q, 32'h4000_0000);
    step();
    chk("R6", "req one cycle", {31'd0, reset_req}, 32'd0);
    evt();
    chk("R5", "cnt cleared -> por", cause_q, 32'h8000_0000);

    // R6 soft external write
    cur = "R6";
    wr(3'd4, 32'h2000_0000, 0);
    chk("R6", "xir req", {31'd0, reset_req}, 32'd1);
    chk("R4", "set bit29", cause_q, 32'hA000_0000);
    // R3 w1c keeps set bits
    cur = "R3";
    wr(3'd4, 32'h9800_0000, 0);
    chk("R3", "w1c", cause_q, 32'h2000_0000);
    chk("R6", "no req on w1c", {31'd0, reset_req}, 32'd0);
    // R4 writing zero no change
    cur = "R4";
    wr(3'd4, 32'h0000_0000, 0);
    chk("R4", "write zero", cause_q, 32'h2000_0000);
    // R10 low-word write ignored
    cur = "R10";
    wr(3'd0, 32'hFFFF_FFFF, 0);
    chk("R10", "lo write", cause_q, 32'h2000_0000);
    chk("R10", "lo no req", {31'd0, reset_req}, 32'd0);
    // R2 reserved bits
    cur = "R2";
    wr(3'd4, 32'h07FF_FFFF, 0);
    chk("R2", "reserved", cause_q, 32'h2000_0000);
    rd(3'd4);
    chk("R2", "reserved rd", rd_data, 32'h2000_0000);

    // R9 saturation: restart counting then exceed range
    cur = "R9";
    wr(3'd4, 32'h4000_0000, 0);
    evt();
    wr(3'd4, 32'h8000_0000, 0);
    chk("R9", "cleared", cause_q, 32'd0);
    for (int i = 0; i < 6; i++) evt();
    chk("R9", "no wrap reload", cause_q, 32'd0);

    // R12 coincident write and event
    cur = "R12";
    wr(3'd4, 32'h4000_0000, 1);
    chk("R12", "spor+evt", cause_q, 32'h8000_0000);
    chk("R12", "spor+evt req", {31'd0, reset_req}, 32'd1);
    evt();
    chk("R12", "cnt one after", cause_q, 32'h8000_0000);
    wr(3'd4, 32'h2000_0000, 1);
    chk("R12", "xir+evt", cause_q, 32'hA000_0000);
    wr(3'd4, 32'h8000_0000, 1);
    chk("R12", "w1c+evt", cause_q, 32'h2000_0000);
    rd_en = 1; rd_addr = 3'd4; wr_en = 1; wr_addr = 3'd4; wr_data = 32'h4000_0000;
    step(); idle();
    chk("R11", "rd before write", rd_data, 32'h2000_0000);

    // R1 re-initialisation
    cur = "R1";
    rst = 1;
    step();
    chk("R1", "cause in rst", cause_q, 32'd0);
    rst = 0;
    step();
    evt();
    chk("R7", "por after init", cause_q, 32'h8000_0000);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule